// File: doc/BRIEF.md
# Clock Configuration Register Target on a Two-Wire Serial Bus

This block is a bus target that holds six 8-bit configuration bytes for a clock generator and lets a bus host load and inspect them over a standard two-wire serial bus (I2C). Both bus lines are sampled by a much faster system clock. The block finds START and STOP conditions and checks the address byte. It pulls SDA low to acknowledge and to send data. The six bytes are always visible as one parallel output vector, so the clock outputs and divider logic can use them without any handshake.

There is no register pointer. A write always carries a command byte and a length byte, and both are acknowledged and then dropped. The data bytes that follow land in byte 0, byte 1 and so on upward, and the host may stop after any whole byte. A read first returns a length byte and then the bytes in ascending order. It continues while the host keeps acknowledging, and it stops at the first host NACK.

Top module: `cfg_i2c_target`

## Requirements
- R1: After reset, `cfg_o` equals the reset value: bytes 3, 4 and 5 (bits 47:24) are 0xFF and bytes 0 to 2 are 0x00, with byte i on bits 8i+7:8i. SDA is released (`sda_oe_o` = 0).
- R2: The address byte 0xD2 (write) and the address byte 0xD3 (read) are both acknowledged, by pulling SDA low during the ninth clock.
- R3: Any other address byte gets no acknowledge. All later bytes up to the next START also get no acknowledge, and the registers stay unchanged.
- R4: In a write, the two bytes that follow the address are acknowledged and their values are discarded.
- R5: The data bytes of a write are stored in ascending order starting at byte 0, MSB first, and each one is acknowledged.
- R6: A STOP after any whole data byte leaves the bytes already written with their new values and every other byte unchanged.
- R7: Data bytes after the sixth are acknowledged, and no register changes.
- R8: A read returns the byte count 0x06 first, then bytes 0, 1, 2 and so on, MSB first. SDA changes only while SCL is low.
- R9: After a NACK from the host on a read byte, the target releases SDA and sends nothing more.
- R10: A STOP in the middle of a byte discards the partial byte, and no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_o | output | 48 | Configuration bytes, byte i on bits 8i+7:8i |

## Verification
Two functions share one detected SCL falling edge. In a read, that edge releases the acknowledge the target has been driving, and the same edge must load the next transmit byte and put its MSB on SDA. In a write, the edge that completes a data byte both commits it to the register bank and starts the acknowledge. Random write lengths from zero to eight bytes and random read lengths, carrying random data with both MSB values, exercise the read hand-over after every acknowledge and the write commit at every index, including the indices that must be ignored. Each received bit is compared against a bench model of the register contents, and every acknowledge slot is compared against the expected acknowledge.

// File: rtl/cfg_i2c_pkg.sv
// Shared constants and the state type of the configuration bus target.
// Assumes 8-bit bus bytes; the address bytes carry the direction bit in bit 0.
package cfg_i2c_pkg;

    localparam int          BYTE_BITS  = 8;
    localparam logic [7:0]  ADDR_WRITE = 8'hD2;
    localparam logic [7:0]  ADDR_READ  = 8'hD3;

    typedef enum logic [2:0] {
        ST_IDLE,   // bus free or transfer ended by STOP
        ST_RX,     // shifting in an address or write byte
        ST_ACK,    // target holds SDA low for the ninth clock
        ST_TX,     // shifting out a read byte
        ST_RACK,   // host acknowledge slot after a read byte
        ST_SKIP    // not addressed, wait for the next START
    } tgt_state_e;

endpackage

// File: rtl/cfg_i2c_line_sync.sv
// Brings SCL and SDA into the clk domain and derives bus events.
// Assumes lines idle high; STAGES flops per line before edge detection.
module cfg_i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] scl_chain;
    logic [CHAIN-1:0] sda_chain;

    // Synchroniser chains with one extra stage holding the previous value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
        end else begin
            scl_chain <= {scl_chain[CHAIN-2:0], scl_i};
            sda_chain <= {sda_chain[CHAIN-2:0], sda_i};
        end
    end

    logic scl_p;
    logic sda_p;

    // Current and previous synchronised line levels.
    always_comb begin
        scl_s = scl_chain[STAGES-1];
        sda_s = sda_chain[STAGES-1];
        scl_p = scl_chain[STAGES];
        sda_p = sda_chain[STAGES];
    end

    // Bus events: SCL edges, and SDA edges while SCL stays high.
    always_comb begin
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    end

endmodule

// File: rtl/cfg_i2c_regbank.sv
// Holds the configuration bytes; one byte written per enable pulse.
// Assumes wr_idx is below NUM_REGS whenever wr_en is high.
module cfg_i2c_regbank #(
    parameter int                      NUM_REGS    = 6,
    parameter logic [NUM_REGS*8-1:0]   RESET_VALUE = '0,
    localparam int                     IDX_W       = $clog2(NUM_REGS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [7:0]              wr_data,
    output logic [NUM_REGS*8-1:0]   cfg_o
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
        // One configuration byte with its own reset value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_o[g*8 +: 8] <= RESET_VALUE[g*8 +: 8];
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                cfg_o[g*8 +: 8] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/cfg_i2c_target.sv
// Two-wire bus target for a clock-generator configuration bank.
// Write: address, command, length (both dropped), then data from byte 0 up.
// Read: length byte, then bytes from 0 up until the host NACKs.
// Assumes clk is at least 16x the SCL rate and no clock stretching is needed.
module cfg_i2c_target
    import cfg_i2c_pkg::*;
#(
    parameter int                      NUM_REGS    = 6,
    parameter logic [NUM_REGS*8-1:0]   RESET_VALUE = 48'hFFFF_FF00_0000,
    parameter int                      SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_oe_o,
    output logic [NUM_REGS*8-1:0]   cfg_o
);

    localparam int IDX_W = $clog2(NUM_REGS);
    localparam int BC_W  = $clog2(NUM_REGS + 3);
    localparam int RD_W  = $clog2(NUM_REGS + 2);
    localparam logic [BC_W-1:0] BC_FIRST = BC_W'(2);
    localparam logic [BC_W-1:0] BC_MAX   = BC_W'(NUM_REGS + 2);
    localparam logic [RD_W-1:0] RD_MAX   = RD_W'(NUM_REGS + 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    cfg_i2c_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    tgt_state_e                state;
    logic [3:0]                bit_cnt;
    logic [BYTE_BITS-1:0]      rx_sr;
    logic [BYTE_BITS-1:0]      tx_sr;
    logic                      addr_phase;
    logic                      rd_mode;
    logic                      host_ack;
    logic [BC_W-1:0]           byte_cnt;
    logic [RD_W-1:0]           rd_cnt;
    logic                      sda_oe;
    logic                      byte_done;
    logic                      wr_en;
    logic [IDX_W-1:0]          wr_idx;
    logic [BYTE_BITS-1:0]      tx_next;

    // A received byte is complete on the SCL fall after its eighth bit.
    always_comb byte_done = (state == ST_RX) && scl_fall && (bit_cnt == 4'd8);

    // Commit request for write bytes that map onto a register.
    always_comb begin
        wr_en  = byte_done && !addr_phase && !rd_mode &&
                 (byte_cnt >= BC_FIRST) && (byte_cnt < BC_MAX);
        wr_idx = IDX_W'(byte_cnt - BC_FIRST);
    end

    // Next read byte: the length first, then the registers, then all ones.
    always_comb begin
        tx_next = 8'hFF;
        if (rd_cnt == '0) begin
            tx_next = 8'(NUM_REGS);
        end
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_cnt == RD_W'(i + 1)) tx_next = cfg_o[i*8 +: 8];
        end
    end

    // Transfer sequencer: bus events move the state, SCL low drives SDA.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            rx_sr      <= '0;
            tx_sr      <= '0;
            addr_phase <= 1'b0;
            rd_mode    <= 1'b0;
            host_ack   <= 1'b0;
            byte_cnt   <= '0;
            rd_cnt     <= '0;
            sda_oe     <= 1'b0;
        end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else if (start_det) begin
            state      <= ST_RX;
            addr_phase <= 1'b1;
            rd_mode    <= 1'b0;
            bit_cnt    <= '0;
            byte_cnt   <= '0;
            rd_cnt     <= '0;
            sda_oe     <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise && bit_cnt != 4'd8) begin
                        rx_sr   <= {rx_sr[BYTE_BITS-2:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_done) begin
                        if (addr_phase) begin
                            addr_phase <= 1'b0;
                            if (rx_sr == ADDR_WRITE) begin
                                rd_mode <= 1'b0;
                                sda_oe  <= 1'b1;
                                state   <= ST_ACK;
                            end else if (rx_sr == ADDR_READ) begin
                                rd_mode <= 1'b1;
                                sda_oe  <= 1'b1;
                                state   <= ST_ACK;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end else begin
                            sda_oe <= 1'b1;
                            state  <= ST_ACK;
                            if (byte_cnt != BC_MAX) byte_cnt <= byte_cnt + BC_W'(1);
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (rd_mode) begin
                            tx_sr  <= tx_next;
                            sda_oe <= ~tx_next[BYTE_BITS-1];
                            state  <= ST_TX;
                            if (rd_cnt != RD_MAX) rd_cnt <= rd_cnt + RD_W'(1);
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bit_cnt == 4'd7) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            state   <= ST_RACK;
                        end else begin
                            tx_sr   <= {tx_sr[BYTE_BITS-2:0], 1'b0};
                            sda_oe  <= ~tx_sr[BYTE_BITS-2];
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        host_ack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (host_ack) begin
                            tx_sr  <= tx_next;
                            sda_oe <= ~tx_next[BYTE_BITS-1];
                            state  <= ST_TX;
                            if (rd_cnt != RD_MAX) rd_cnt <= rd_cnt + RD_W'(1);
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    cfg_i2c_regbank #(
        .NUM_REGS    (NUM_REGS),
        .RESET_VALUE (RESET_VALUE)
    ) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (rx_sr),
        .cfg_o   (cfg_o)
    );

    // Drive the pad enable from the sequencer register.
    always_comb sda_oe_o = sda_oe;

endmodule

// File: rtl/cfg_i2c_checker.sv
// Protocol and register-bank properties of the configuration bus target.
// Assumes it is bound to cfg_i2c_target and sees its internal signals.
module cfg_i2c_checker #(
    parameter int                      NUM_REGS    = 6,
    parameter logic [NUM_REGS*8-1:0]   RESET_VALUE = '0,
    localparam int                     IDX_W       = $clog2(NUM_REGS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_s,
    input  logic                    sda_oe_o,
    input  logic [NUM_REGS*8-1:0]   cfg_o,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic                    in_skip
);

    logic rst_seen;

    // Remembers that reset was asserted on the previous edge.
    always_ff @(posedge clk) rst_seen <= !rst_n;

    // R1: first cycle out of reset shows the reset value and a released line.
    assert_reset_value_R1: assert property (@(posedge clk)
        (rst_n && rst_seen) |-> (cfg_o == RESET_VALUE && !sda_oe_o));

    // R3 / R9: an unaddressed or finished target never pulls SDA.
    assert_quiet_when_skipping_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_skip |-> !sda_oe_o);

    // R5: configuration bytes change only on the cycle after a commit.
    assert_change_needs_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_o != $past(cfg_o)) |-> $past(wr_en));

    // R7: a commit never targets an index beyond the bank.
    assert_commit_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < IDX_W'(NUM_REGS)));

    // R8: SDA drive stays constant while synchronised SCL stays high.
    assert_sda_hold_scl_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe_o));

endmodule

bind cfg_i2c_target cfg_i2c_checker #(
    .NUM_REGS    (NUM_REGS),
    .RESET_VALUE (RESET_VALUE)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe_o (sda_oe_o),
    .cfg_o    (cfg_o),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .in_skip  (state == cfg_i2c_pkg::ST_SKIP)
);

// File: tb/test_cfg_i2c_target.sv
// Bench for cfg_i2c_target: a bus host model drives SCL and SDA (open drain),
// a byte array models the expected register contents.
module test_cfg_i2c_target;

    localparam int          NREG = 6;
    localparam int          Q    = 8;
    localparam logic [47:0] DEF  = {8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_drv = 1'b1;
    logic        host_low = 1'b0;
    logic        dut_oe;
    logic        sda_line;
    logic [47:0] cfg;

    int tests = 0;
    int fails = 0;
    logic [7:0] model [NREG];

    always #2 clk = ~clk;

    always_comb sda_line = !(host_low || dut_oe);

    cfg_i2c_target i_cfg_i2c_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_drv),
        .sda_i    (sda_line),
        .sda_oe_o (dut_oe),
        .cfg_o    (cfg)
    );

    // Counts one comparison and reports a mismatch.
    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [47:0] model_vec();
        logic [47:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
        return v;
    endfunction

    task automatic wait_q();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    // One SCL pulse; samples SDA in the middle of the high phase.
    task automatic slot(output logic smp);
        wait_q();
        scl_drv = 1'b1;
        wait_q();
        smp = sda_line;
        wait_q();
        scl_drv = 1'b0;
        wait_q();
    endtask

    task automatic bus_start();
        host_low = 1'b0;
        wait_q();
        scl_drv = 1'b1;
        wait_q();
        host_low = 1'b1;
        wait_q();
        scl_drv = 1'b0;
        wait_q();
    endtask

    task automatic bus_stop();
        host_low = 1'b1;
        wait_q();
        scl_drv = 1'b1;
        wait_q();
        host_low = 1'b0;
        wait_q();
        wait_q();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        logic s;
        for (int i = 7; i > 7 - n; i--) begin
            host_low = ~b[i];
            slot(s);
        end
    endtask

    // Sends a byte and returns 1 when the target acknowledged it.
    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        send_bits(b, 8);
        host_low = 1'b0;
        slot(s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        host_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            slot(s);
            b[i] = s;
        end
        host_low = give_ack;
        slot(s);
        host_low = 1'b0;
    endtask

    // Full write: address, random command and length, then n data bytes.
    task automatic do_write(input int n, input logic [7:0] data [10]);
        logic a;
        bus_start();
        send_byte(8'hD2, a);
        check("R2 write address ack", a, 1'b1);
        send_byte(8'($urandom), a);
        check("R4 command byte ack", a, 1'b1);
        send_byte(8'($urandom), a);
        check("R4 length byte ack", a, 1'b1);
        for (int i = 0; i < n; i++) begin
            send_byte(data[i], a);
            if (i < NREG) begin
                check("R5 data byte ack", a, 1'b1);
                model[i] = data[i];
            end else begin
                check("R7 surplus byte ack", a, 1'b1);
            end
        end
        bus_stop();
        check("R6 registers after stop", cfg, model_vec());
    endtask

    // Read: length byte then n register bytes, NACK on the last byte taken.
    task automatic do_read(input int n);
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD3, a);
        check("R2 read address ack", a, 1'b1);
        recv_byte(n != 0, b);
        check("R8 byte count", b, 8'h06);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            check("R8 read byte", b, model[i]);
        end
        check("R9 sda released after nack", sda_line, 1'b1);
        wait_q();
        check("R9 target silent after nack", dut_oe, 1'b0);
        bus_stop();
    endtask

    initial begin
        logic [7:0] d [10];
        logic a;
        void'($urandom(32'd5150));
        for (int i = 0; i < NREG; i++) model[i] = DEF[i*8 +: 8];
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        wait_q();
        check("R1 reset value", cfg, DEF);
        check("R1 sda released", dut_oe, 1'b0);

        // Directed: full write then full read.
        for (int i = 0; i < 10; i++) d[i] = 8'h11 * 8'(i + 1);
        d[0] = 8'h80;
        d[1] = 8'h7F;
        do_write(6, d);
        do_read(6);

        // R7: eight data bytes, the last two must not land anywhere.
        for (int i = 0; i < 10; i++) d[i] = 8'hA0 + 8'(i);
        do_write(8, d);
        check("R7 bank after surplus", cfg, model_vec());

        // R6: short write touches only bytes 0 and 1.
        d[0] = 8'h3C;
        d[1] = 8'hC3;
        do_write(2, d);
        check("R6 untouched upper bytes", cfg[47:16], {8'hA5, 8'hA4, 8'hA3, 8'hA2});

        // R3: foreign addresses are ignored until the next START.
        bus_start();
        send_byte(8'hA4, a);
        check("R3 foreign address nack", a, 1'b0);
        send_byte(8'h00, a);
        check("R3 following byte nack", a, 1'b0);
        send_byte(8'h55, a);
        check("R3 third byte nack", a, 1'b0);
        bus_stop();
        bus_start();
        send_byte(8'hD0, a);
        check("R3 near-miss address nack", a, 1'b0);
        bus_stop();
        check("R3 registers unchanged", cfg, model_vec());

        // R10: STOP in the middle of the first data byte.
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        send_byte(8'h06, a);
        send_bits(8'h00, 4);
        bus_stop();
        check("R10 partial byte dropped", cfg, model_vec());

        // R9: read stopped early by a NACK.
        do_read(2);
        do_read(0);

        // Random writes and reads of random length.
        for (int k = 0; k < 10; k++) begin
            for (int i = 0; i < 10; i++) d[i] = 8'($urandom);
            do_write(int'($urandom_range(0, 8)), d);
            do_read(int'($urandom_range(0, 6)));
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule